// File: doc/BRIEF.md
# Interrupt Enable Flag Controller

This block keeps the maskable-interrupt enable state of a small 8-bit-class CPU core and decides, at each instruction boundary, whether the core takes an interrupt. It holds two flags. The live flag gates maskable requests. The saved flag holds a copy that survives a nonmaskable interrupt. The instruction decoder reports every completed instruction with a strobe, together with one-cycle decoded strobes for enable-interrupt, disable-interrupt and return-from-nonmaskable. Two request lines come in: a nonmaskable one, which is taken on its rising edge, and a maskable one, which is taken while it is held high.

Acceptance is decided only in a cycle where the instruction-complete strobe is high. The flags used for that decision are the values left after the completing instruction has taken effect. The decision appears on the acknowledge outputs one clock later as a single-cycle pulse. The flags are updated on that same clock edge.

An enable instruction does not open the maskable path at once. The boundary at which the enable completes is blocked, and the path opens at the completion of the instruction that follows it. The saved flag drives an output so that the core can copy it into its parity status bit when it executes the instructions that read the vector-base or refresh register.

Top module: `irq_enable_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both flags and both acknowledge outputs are 0.
- R2: When an enable-interrupt instruction completes, both flags become 1. When a disable-interrupt instruction completes, both flags become 0. A flag change is visible on the cycle after the strobe.
- R3: Maskable acceptance is blocked at the boundary where an enable-interrupt instruction completes. It becomes possible at the next instruction completion.
- R4: A maskable request is accepted at a completion only when the live flag, after that instruction's effect, is 1. Acceptance pulses int_ack for one cycle and clears both flags.
- R5: A rising edge on nmi_req stays pending until the next completion, where it is accepted whatever the flags are. A request held high yields exactly one nmi_ack. A level that is already high when reset is released counts as one edge.
- R6: On nonmaskable acceptance, the saved flag takes the live value that the completing instruction left, and the live flag becomes 0.
- R7: Completion of a return-from-nonmaskable instruction copies the saved flag into the live flag and leaves the saved flag unchanged.
- R8: When both interrupt types can be accepted at the same completion, only nmi_ack pulses.
- R9: A disable-interrupt instruction that completes directly after an enable-interrupt instruction leaves both flags at 0 and produces no maskable acceptance at either boundary.
- R10: nmi_ack and int_ack are never high together. Each pulses only in the cycle after an instruction-complete strobe.
- R11: The ief_saved output always shows the current saved flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | One-cycle strobe: an instruction has completed |
| op_ei | input | 1 | The completing instruction is enable-interrupt (valid with instr_done) |
| op_di | input | 1 | The completing instruction is disable-interrupt (valid with instr_done) |
| op_retn | input | 1 | The completing instruction is return-from-nonmaskable (valid with instr_done) |
| nmi_req | input | 1 | Nonmaskable request, rising-edge sensitive |
| int_req | input | 1 | Maskable request, level sensitive |
| nmi_ack | output | 1 | One-cycle pulse: nonmaskable interrupt accepted |
| int_ack | output | 1 | One-cycle pulse: maskable interrupt accepted |
| ief_live | output | 1 | Live maskable-enable flag |
| ief_saved | output | 1 | Saved enable flag, for copying into the parity status bit |

## Verification
The properties assume that the decoder raises at most one of op_ei, op_di and op_retn at a time, and only in a cycle where instr_done is high. The return-flag property also relies on no acceptance happening at the same boundary. The stimulus generator draws the decoded operation as a single choice per completed instruction and holds every operation strobe low when no instruction completes, so it never leaves these limits. Directed sequences are placed between the random runs to reach the enable delay, a disable immediately after an enable, simultaneous requests, and a nonmaskable request that stays high.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_ENABLE  = 2'd1,
        OP_DISABLE = 2'd2,
        OP_RESTORE = 2'd3
    } op_kind_t;

    typedef struct packed {
        logic live;
        logic saved;
        logic mark;
    } flag_state_t;

    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_state_t;

    typedef struct packed {
        logic nmi_ack;
        logic int_ack;
    } ack_state_t;

    // Disable dominates, then enable, then restore; nothing without a strobe.
    function automatic op_kind_t decode_op(input logic done, input logic ei,
                                           input logic di, input logic retn);
        op_kind_t k;
        k = OP_NONE;
        if (done) begin
            if (di)        k = OP_DISABLE;
            else if (ei)   k = OP_ENABLE;
            else if (retn) k = OP_RESTORE;
        end
        return k;
    endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic take_nmi,
    output logic nmi_pend
);
    nmi_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d      = st_q;
        rise      = nmi_req & ~st_q.prev;
        st_d.prev = nmi_req;
        // A new edge in the acceptance cycle re-arms the pending bit.
        st_d.pend = rise | (st_q.pend & ~take_nmi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nmi_pend = st_q.pend;
endmodule

// File: rtl/irq_flag_core.sv
module irq_flag_core
    import irq_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     instr_done,
    input  op_kind_t op,
    input  logic     take_nmi,
    input  logic     take_int,
    output logic     live_eff,
    output logic     mark_next,
    output logic     live_q,
    output logic     saved_q
);
    flag_state_t st_d, st_q;
    logic        saved_eff;

    // Flag values once the completing instruction has acted.
    always_comb begin
        live_eff  = st_q.live;
        saved_eff = st_q.saved;
        unique case (op)
            OP_ENABLE:  begin live_eff = 1'b1;     saved_eff = 1'b1; end
            OP_DISABLE: begin live_eff = 1'b0;     saved_eff = 1'b0; end
            OP_RESTORE: begin live_eff = st_q.saved;                 end
            default:    begin                                        end
        endcase
        mark_next = instr_done ? (op == OP_ENABLE) : st_q.mark;
    end

    always_comb begin
        st_d      = st_q;
        st_d.mark = mark_next;
        if (instr_done) begin
            if (take_nmi) begin
                st_d.saved = live_eff;
                st_d.live  = 1'b0;
            end else if (take_int) begin
                st_d.saved = 1'b0;
                st_d.live  = 1'b0;
            end else begin
                st_d.saved = saved_eff;
                st_d.live  = live_eff;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_q  = st_q.live;
    assign saved_q = st_q.saved;
endmodule

// File: rtl/irq_accept_arb.sv
module irq_accept_arb
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_done,
    input  logic nmi_pend,
    input  logic int_req,
    input  logic live_eff,
    input  logic mark_next,
    output logic take_nmi,
    output logic take_int,
    output logic nmi_ack,
    output logic int_ack
);
    ack_state_t st_d, st_q;

    always_comb begin
        take_nmi = instr_done & nmi_pend;
        // Maskable path: enabled, not in the enable shadow, no NMI this boundary.
        take_int = instr_done & int_req & live_eff & ~mark_next & ~take_nmi;
        st_d.nmi_ack = take_nmi;
        st_d.int_ack = take_int;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nmi_ack = st_q.nmi_ack;
    assign int_ack = st_q.int_ack;
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_done,
    input  logic op_ei,
    input  logic op_di,
    input  logic op_retn,
    input  logic nmi_req,
    input  logic int_req,
    output logic nmi_ack,
    output logic int_ack,
    output logic ief_live,
    output logic ief_saved
);
    op_kind_t op;
    logic     nmi_pend;
    logic     take_nmi;
    logic     take_int;
    logic     live_eff;
    logic     mark_next;

    assign op = decode_op(instr_done, op_ei, op_di, op_retn);

    irq_nmi_latch u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_req  (nmi_req),
        .take_nmi (take_nmi),
        .nmi_pend (nmi_pend)
    );

    irq_flag_core u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .op         (op),
        .take_nmi   (take_nmi),
        .take_int   (take_int),
        .live_eff   (live_eff),
        .mark_next  (mark_next),
        .live_q     (ief_live),
        .saved_q    (ief_saved)
    );

    irq_accept_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .nmi_pend   (nmi_pend),
        .int_req    (int_req),
        .live_eff   (live_eff),
        .mark_next  (mark_next),
        .take_nmi   (take_nmi),
        .take_int   (take_int),
        .nmi_ack    (nmi_ack),
        .int_ack    (int_ack)
    );
endmodule

// File: rtl/irq_enable_ctrl_chk.sv
module irq_enable_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic instr_done,
    input logic op_ei,
    input logic op_di,
    input logic op_retn,
    input logic nmi_ack,
    input logic int_ack,
    input logic ief_live,
    input logic ief_saved
);
    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_ack && int_ack)); // R10

    AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_ack || int_ack) |-> $past(instr_done)); // R10

    AST_NO_INT_AT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> !$past(op_ei)); // R3

    AST_INT_CLEARS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> (!ief_live && !ief_saved)); // R4

    AST_NMI_CLEARS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack |-> !ief_live); // R6

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(instr_done && op_di) |-> (!ief_live && !ief_saved && !int_ack)); // R2

    AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(instr_done && op_ei && !op_di) && !nmi_ack) |-> (ief_live && ief_saved)); // R2

    AST_RESTORE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(instr_done && op_retn && !op_ei && !op_di) && !nmi_ack && !int_ack)
            |-> (ief_live == $past(ief_saved) && $stable(ief_saved))); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(instr_done) |-> ($stable(ief_live) && $stable(ief_saved))); // R11
endmodule

bind irq_enable_ctrl irq_enable_ctrl_chk chk_i (.*);

// File: tb/irq_enable_ctrl_tb_top.sv
module irq_enable_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_STEPS = 4000;
    localparam int WATCHDOG_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_done = 1'b0, op_ei = 1'b0, op_di = 1'b0, op_retn = 1'b0;
    logic nmi_req = 1'b0, int_req = 1'b0;
    logic nmi_ack, int_ack, ief_live, ief_saved;

    int checks = 0;
    int fails = 0;
    bit done_flag = 1'b0;

    // reference state
    logic m_live = 0, m_saved = 0, m_mark = 0, m_pend = 0, m_prev = 0;
    logic m_nack = 0, m_iack = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_enable_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .op_ei(op_ei),
        .op_di(op_di), .op_retn(op_retn), .nmi_req(nmi_req), .int_req(int_req),
        .nmi_ack(nmi_ack), .int_ack(int_ack), .ief_live(ief_live), .ief_saved(ief_saved)
    );

    function automatic logic eff_live(input logic done, ei, di, retn, live, saved);
        if (!done) return live;
        if (di)    return 1'b0;
        if (ei)    return 1'b1;
        if (retn)  return saved;
        return live;
    endfunction

    function automatic logic eff_saved(input logic done, ei, di, saved);
        if (!done) return saved;
        if (di)    return 1'b0;
        if (ei)    return 1'b1;
        return saved;
    endfunction

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        check1(tag, "nmi_ack",   nmi_ack,   m_nack);
        check1(tag, "int_ack",   int_ack,   m_iack);
        check1(tag, "ief_live",  ief_live,  m_live);
        check1(tag, "ief_saved", ief_saved, m_saved);
    endtask

    // drive at negedge, update the reference at the edge, sample after it
    task automatic step(input string tag, input logic d, ei, di, retn, nmi, irq);
        logic le, se, mk, tn, ti, rise;
        @(negedge clk);
        instr_done = d; op_ei = d & ei; op_di = d & di; op_retn = d & retn;
        nmi_req = nmi; int_req = irq;
        @(posedge clk);
        rise = nmi & ~m_prev;
        le = eff_live(d, ei, di, retn, m_live, m_saved);
        se = eff_saved(d, ei, di, m_saved);
        mk = d ? (ei & ~di) : m_mark;
        tn = d & m_pend;
        ti = d & irq & le & ~mk & ~tn;
        if (d) begin
            if (tn)      begin m_saved = le; m_live = 1'b0; end
            else if (ti) begin m_saved = 1'b0; m_live = 1'b0; end
            else         begin m_saved = se; m_live = le; end
        end
        m_mark = mk;
        m_pend = rise | (m_pend & ~tn);
        m_prev = nmi;
        m_nack = tn;
        m_iack = ti;
        #1;
        check_all(tag);
    endtask

    initial begin
        @(posedge done_flag);
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D));
        // R1: reset state, during and right after reset
        repeat (3) @(posedge clk);
        #1; check_all("R1");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1; check_all("R1");

        // R3: enable completes with a request waiting, no acceptance there
        step("R2", 1, 1, 0, 0, 0, 1);
        check1("R3", "int_ack at enable", int_ack, 1'b0);
        step("R3", 0, 0, 0, 0, 0, 1);
        step("R4", 1, 0, 0, 0, 0, 1);          // following instruction completes -> accept
        check1("R4", "int_ack after delay", int_ack, 1'b1);
        step("R4", 0, 0, 0, 0, 0, 0);

        // R9: enable then disable immediately
        step("R9", 1, 1, 0, 0, 0, 1);
        step("R9", 1, 0, 1, 0, 0, 1);
        check1("R9", "live after di", ief_live, 1'b0);
        step("R9", 1, 0, 0, 0, 0, 1);
        check1("R9", "no int_ack", int_ack, 1'b0);

        // R5: NMI with flags clear, held high -> one ack only
        step("R5", 0, 0, 0, 0, 1, 0);
        step("R5", 1, 0, 0, 0, 1, 0);
        check1("R5", "nmi_ack", nmi_ack, 1'b1);
        for (int i = 0; i < 6; i++) step("R5", 1, 0, 0, 0, 1, 0);
        step("R5", 1, 0, 0, 0, 0, 0);

        // R6/R7: enabled, NMI saves live, return restores
        step("R2", 1, 1, 0, 0, 0, 0);
        step("R2", 1, 0, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 1, 0);
        step("R6", 1, 0, 0, 0, 1, 0);
        check1("R6", "saved", ief_saved, 1'b1);
        check1("R6", "live", ief_live, 1'b0);
        step("R7", 1, 0, 0, 1, 0, 0);
        check1("R7", "live restored", ief_live, 1'b1);
        check1("R11", "saved kept", ief_saved, 1'b1);

        // R8: both pending
        step("R8", 0, 0, 0, 0, 1, 1);
        step("R8", 1, 0, 0, 0, 1, 1);
        check1("R8", "nmi wins", nmi_ack, 1'b1);
        check1("R8", "no int_ack", int_ack, 1'b0);
        step("R8", 1, 0, 0, 0, 0, 1);

        // random phase
        for (int i = 0; i < RAND_STEPS; i++) begin
            logic d, ei, di, rt, nm, ir;
            int sel;
            d = ($urandom_range(0, 2) != 0);
            sel = $urandom_range(0, 7);
            ei = (sel == 0) || (sel == 1);
            di = (sel == 2);
            rt = (sel == 3);
            nm = ($urandom_range(0, 9) == 0) ? ~nmi_req : nmi_req;
            ir = ($urandom_range(0, 3) != 0);
            step("R10", d, ei, di, rt, nm, ir);
        end

        // reset again mid-run: R1
        @(negedge clk); rst_n = 1'b0;
        m_live = 0; m_saved = 0; m_mark = 0; m_pend = 0; m_prev = 0; m_nack = 0; m_iack = 0;
        instr_done = 0; op_ei = 0; op_di = 0; op_retn = 0; nmi_req = 0; int_req = 0;
        #1; check_all("R1");
        @(negedge clk); rst_n = 1'b1;
        step("R1", 0, 0, 0, 0, 0, 0);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule